// File: doc/BRIEF.md
# SPI Master with Mode-Fault Fallback

This block is an SPI bus master that moves one byte per transfer in SPI mode 0, most significant bit first. Software drives it through a small register port with three registers: control, data and flags. Writing the data register while the master is enabled and idle starts a transfer. The serial clock runs at the system clock divided by `2*HALF_DIV` and stays low whenever no transfer is running. When a transfer finishes, the received byte lands in a receive buffer that software reads through the data register. Transmit has a single buffer, so a second write while a byte is still shifting is refused and reported as a write collision.

The block also lets several masters share one bus. When the slave-select pin is configured as an input and slave-select handling is enabled, a low level on the pin means another master has claimed the bus. The block then clears its own master-enable bit, abandons any transfer in progress, turns its pin drivers around to slave directions and raises the completion flag. It stays a slave until software sets master-enable again.

The register port has no back-pressure. Every write and read strobe is taken in the cycle it is presented. Read data is combinational from the address. Reading the data register has a side effect, applied at the clock edge that ends the read cycle.

Top module: `spi_host_mf`

## Requirements
- R1: After reset the control and flags registers read 0, `sck_o` is low, `irq_o` is low, and the pins are in slave directions (`sck_oe`=0, `mosi_oe`=0, `miso_oe`=1).
- R2: A transfer sends the written byte MSB first. `mosi_o` changes only while `sck_o` is low and is stable while `sck_o` is high (mode 0).
- R3: `sck_o` stays high for `HALF_DIV` clock cycles in each bit. It is low whenever master-enable (control bit 0) is clear.
- R4: `miso_i` is sampled on each rising `sck_o`. At the end of the eighth bit the received byte goes into the receive buffer, which the data register (address 1) returns, and flags bit 0 (done) is set.
- R5: If two transfers complete without a data-register read in between, the data register returns the byte from the second transfer.
- R6: A data-register write while a transfer is running sets flags bit 1 (collision), starts nothing, and leaves the byte being shifted unchanged.
- R7: Reading the data register clears flags bits 0 and 1. Reading the flags register (address 2) clears nothing.
- R8: With master-enable set, control bit 1 (ignore-SS) clear and control bit 3 (SS-is-output) clear, a low `ss_i` clears master-enable, aborts the transfer with `sck_o` low, and sets flags bit 0.
- R9: With ignore-SS set, a low `ss_i` has no effect and transfers complete normally.
- R10: With SS-is-output set, a low `ss_i` has no effect, and `ss_oe` is driven high.
- R11: After a mode fault, master-enable stays clear and data writes start no transfer until software writes control bit 0 to 1 again.
- R12: `irq_o` is high exactly when control bit 2 (interrupt enable) and flags bit 0 are both set.
- R13: With master-enable set, `sck_oe`=1, `mosi_oe`=1 and `miso_oe`=0. With master-enable clear, the three are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data reads) |
| reg_addr | input | 2 | 0 control, 1 data, 2 flags |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out (master role) |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_i | input | 1 | Serial data in |
| miso_o | output | 1 | MSB of the last written byte, for the slave role |
| miso_oe | output | 1 | MISO driver enable (slave role) |
| ss_i | input | 1 | Slave-select pin level |
| ss_oe | output | 1 | Slave-select driver enable (SS-is-output bit) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a competing master pulling slave-select low in the middle of a byte. The abort must land with the clock low, and the pins must turn around before software touches anything. The bench starts a transfer itself and drives `ss_i` low a few cycles in, while its scoreboard discards the partial byte. It then checks that data writes start nothing until master-enable is rewritten. The collision case is reached the same way: a second data write is issued a few cycles after the first, while the byte is certainly still shifting.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_DATA  = 2'd1,
    A_FLAGS = 2'd2
  } reg_sel_e;

  // control register layout, bit 0 first from the right
  typedef struct packed {
    logic ss_drive;   // bit 3: SS pin configured as output
    logic irq_en;     // bit 2
    logic ss_ignore;  // bit 1: SS pin not used by the SPI
    logic host_en;    // bit 0: master enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_mf_ssmon.sv
module spi_mf_ssmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_i,
  input  logic host_en,
  input  logic ss_ignore,
  input  logic ss_drive,
  output logic fault
);
  logic ss_level;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ss_i};
      end
      assign ss_level = sync_q[SYNC_STAGES-1];
    end else begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= ss_i;
      end
      assign ss_level = sync_q;
    end
  endgenerate

  // another master claims the bus only when SS is an input taking part in SPI
  assign fault = host_en && !ss_ignore && !ss_drive && !ss_level;
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int DW       = 8,
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          abort,
  input  logic          miso_i,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

  logic [CNT_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    tx_sh;
  logic [DW-1:0]    rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy  <= 1'b0;
        sck   <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
      end else if (start && !busy) begin
        busy  <= 1'b1;
        sck   <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
        tx_sh <= tx_byte;
      end else if (busy) begin
        if (div_q == CNT_LAST) begin
          div_q <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DW-2:0], miso_i};
          end else begin
            sck <= 1'b0;
            if (bit_q == BIT_LAST) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              rx_byte <= rx_sh;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mosi = busy && tx_sh[DW-1];
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DW-1:0]     rx_byte,
  input  logic              fault,
  output ctrl_t             ctrl,
  output logic              start,
  output logic              abort,
  output logic [DW-1:0]     tx_hold,
  output logic              done_flag,
  output logic              wcol_flag,
  output logic              irq
);
  logic          wr_ctrl, wr_data, rd_data;
  logic [DW-1:0] rx_buf;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign rd_data = reg_rd && (reg_addr == A_DATA);

  assign start = wr_data && ctrl.host_en && !busy && !fault;
  assign abort = fault || !ctrl.host_en || (wr_ctrl && !reg_wdata[0]);
  assign irq   = ctrl.irq_en && done_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      rx_buf    <= '0;
      tx_hold   <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (fault)   ctrl.host_en <= 1'b0;

      if (done || fault)  done_flag <= 1'b1;
      else if (rd_data)   done_flag <= 1'b0;

      if (wr_data && ctrl.host_en && busy) wcol_flag <= 1'b1;
      else if (rd_data)                    wcol_flag <= 1'b0;

      if (done)    rx_buf  <= rx_byte;
      if (wr_data) tx_hold <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl);
      A_DATA:  reg_rdata = rx_buf;
      A_FLAGS: reg_rdata = DW'({wcol_flag, done_flag});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_mf.sv
module spi_host_mf
  import spi_mf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_oe,
  output logic              irq_o
);
  ctrl_t         ctrl;
  logic          start, abort, busy, done, fault;
  logic          done_flag, wcol_flag;
  logic [DW-1:0] rx_byte, tx_hold;
  logic          host_en_w;

  assign host_en_w = ctrl.host_en;

  spi_mf_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .rx_byte(rx_byte), .fault(fault),
    .ctrl(ctrl), .start(start), .abort(abort), .tx_hold(tx_hold),
    .done_flag(done_flag), .wcol_flag(wcol_flag), .irq(irq_o)
  );

  spi_mf_shifter #(.DW(DW), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .tx_byte(reg_wdata), .abort(abort), .miso_i(miso_i),
    .busy(busy), .sck(sck_o), .mosi(mosi_o), .done(done), .rx_byte(rx_byte)
  );

  spi_mf_ssmon #(.SYNC_STAGES(SYNC_STAGES)) u_ssmon (
    .clk(clk), .rst_n(rst_n), .ss_i(ss_i),
    .host_en(ctrl.host_en), .ss_ignore(ctrl.ss_ignore), .ss_drive(ctrl.ss_drive),
    .fault(fault)
  );

  // pin directions follow the current role
  assign sck_oe  = host_en_w;
  assign mosi_oe = host_en_w;
  assign miso_oe = !host_en_w;
  assign miso_o  = tx_hold[DW-1];
  assign ss_oe   = ctrl.ss_drive;
endmodule

// File: rtl/spi_host_mf_chk.sv
module spi_host_mf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       host_en,
  input logic       busy,
  input logic       fault,
  input logic       wcol
);
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> $stable(mosi_o));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |-> !sck_o);

  p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && host_en && busy) |=> wcol);

  p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !host_en);

  p_stay_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !(reg_wr && reg_addr == 2'd0)) |=> !host_en);
endmodule

bind spi_host_mf spi_host_mf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .sck_o(sck_o), .mosi_o(mosi_o), .host_en(host_en_w), .busy(busy),
  .fault(fault), .wcol(wcol_flag)
);

// File: tb/spi_host_mf_bench.sv
`timescale 1ns/1ps
module spi_host_mf_bench;
  localparam int HALF = 2;
  localparam int XFER_WAIT = 16 * HALF + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
  logic       ss_i = 1'b1, ss_oe, irq_o;

  int n_cmp = 0, n_err = 0;
  logic [7:0] q_tx[$];
  logic [7:0] slv_byte = 8'h00;
  int slv_idx = 0, nbits = 0, hi_len = 0;
  logic [7:0] cap = 8'h00;
  logic prev_sck = 1'b0, skip_hi = 1'b0, done_all = 1'b0;

  always #10 clk = ~clk;

  assign miso_i = (slv_idx < 8) ? slv_byte[7 - slv_idx] : 1'b0;

  spi_host_mf #(.DW(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) u_spi_host_mf (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_oe(ss_oe), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: prepare slave reply, push expected MOSI byte, start transfer
  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rx);
    @(negedge clk);
    slv_byte = rx; slv_idx = 0; nbits = 0;
    q_tx.push_back(tx);
    reg_write(2'd1, tx);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input bit rd, input string req);
    logic [7:0] v;
    start_xfer(tx, rx);
    repeat (XFER_WAIT) @(negedge clk);
    reg_read(2'd2, v);
    check({req, " done flag"}, 32'(v[0]), 32'd1);
    if (rd) begin
      reg_read(2'd1, v);
      check({req, " rx byte"}, 32'(v), 32'(rx));
    end
  endtask

  task automatic expect_idle(input string req);
    int hits = 0;
    repeat (40) begin
      @(negedge clk);
      if (sck_o) hits++;
    end
    check({req, " sck idle"}, 32'(hits), 32'd0);
  endtask

  // monitor: capture MOSI on rising SCK, advance slave on falling SCK
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sck_o && !prev_sck) begin
        cap = {cap[6:0], mosi_o};
        nbits++;
        hi_len = 1;
      end else if (sck_o) begin
        hi_len++;
      end
      if (!sck_o && prev_sck) begin
        if (!skip_hi) check("R3 sck high length", 32'(hi_len), 32'(HALF));
        slv_idx++;
        if (nbits == 8) begin
          if (q_tx.size() == 0) check("R2 unexpected byte", 32'(cap), 32'hFFFF);
          else check("R2 mosi byte", 32'(cap), 32'(q_tx.pop_front()));
          nbits = 0;
        end
      end
      prev_sck = sck_o;
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done_all) begin
      n_err++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, v); check("R1 ctrl", 32'(v), 32'd0);
    reg_read(2'd2, v); check("R1 flags", 32'(v), 32'd0);
    check("R1 sck", 32'(sck_o), 32'd0);
    check("R1 dirs", 32'({sck_oe, mosi_oe, miso_oe, irq_o}), 32'b0010);

    // R13 master directions
    reg_write(2'd0, 8'h01);
    @(negedge clk);
    check("R13 master dirs", 32'({sck_oe, mosi_oe, miso_oe}), 32'b110);

    // R2/R3/R4 several patterns
    xfer(8'hA5, 8'h3C, 1, "R4 a5");
    xfer(8'h00, 8'hFF, 1, "R4 00");
    xfer(8'hFF, 8'h00, 1, "R4 ff");
    xfer(8'h81, 8'h7E, 1, "R4 81");

    // R5 overrun, R7 flags read leaves flags
    xfer(8'h12, 8'hC3, 0, "R5 first");
    reg_read(2'd2, v); check("R7 flags read no clear", 32'(v[0]), 32'd1);
    xfer(8'h34, 8'h5A, 1, "R5 second");
    reg_read(2'd2, v); check("R7 flags cleared", 32'(v), 32'd0);

    // R6 write collision
    start_xfer(8'h96, 8'hE1);
    repeat (6) @(negedge clk);
    reg_write(2'd1, 8'h11);
    reg_read(2'd2, v); check("R6 collision flag", 32'(v), 32'b10);
    repeat (XFER_WAIT) @(negedge clk);
    reg_read(2'd1, v); check("R6 rx intact", 32'(v), 32'hE1);
    reg_read(2'd2, v); check("R7 both flags cleared", 32'(v), 32'd0);
    expect_idle("R6 no restart");

    // R12 interrupt
    reg_write(2'd0, 8'h05);
    check("R12 irq low", 32'(irq_o), 32'd0);
    xfer(8'h5C, 8'h24, 0, "R12");
    check("R12 irq high", 32'(irq_o), 32'd1);
    reg_read(2'd1, v);
    @(negedge clk);
    check("R12 irq cleared", 32'(irq_o), 32'd0);

    // R8 mode fault mid-transfer
    @(negedge clk);
    slv_byte = 8'h0F; slv_idx = 0; nbits = 0;
    reg_write(2'd1, 8'hF0);
    repeat (7) @(negedge clk);
    skip_hi = 1'b1;
    ss_i = 1'b0;
    repeat (5) @(negedge clk);
    nbits = 0;
    reg_read(2'd0, v); check("R8 master cleared", 32'(v[0]), 32'd0);
    reg_read(2'd2, v); check("R8 flag set", 32'(v[0]), 32'd1);
    check("R8 sck low", 32'(sck_o), 32'd0);
    check("R13 slave dirs", 32'({sck_oe, mosi_oe, miso_oe}), 32'b001);
    check("R8 irq", 32'(irq_o), 32'd1);
    reg_read(2'd1, v);

    // R11 stays slave until rewritten
    ss_i = 1'b1;
    repeat (5) @(negedge clk);
    skip_hi = 1'b0;
    nbits = 0;
    reg_read(2'd0, v); check("R11 still slave", 32'(v[0]), 32'd0);
    reg_write(2'd1, 8'h77);
    expect_idle("R11 write ignored");
    reg_read(2'd2, v); check("R11 no flags", 32'(v), 32'd0);
    reg_write(2'd0, 8'h01);
    xfer(8'hC6, 8'h39, 1, "R11 restored");

    // R9 ignore-SS
    reg_write(2'd0, 8'h03);
    ss_i = 1'b0;
    xfer(8'h6B, 8'hD2, 1, "R9");
    reg_read(2'd0, v); check("R9 master kept", 32'(v[0]), 32'd1);
    ss_i = 1'b1;

    // R10 SS as output
    reg_write(2'd0, 8'h09);
    check("R10 ss_oe", 32'(ss_oe), 32'd1);
    ss_i = 1'b0;
    xfer(8'h2E, 8'hB4, 1, "R10");
    reg_read(2'd0, v); check("R10 master kept", 32'(v[0]), 32'd1);
    ss_i = 1'b1;

    check("R2 queue drained", 32'(q_tx.size()), 32'd0);
    done_all = 1'b1;
    finish_run();
  end
endmodule